// File: doc/BRIEF.md
# DMA Manager Security Gate

This block sits behind the instruction decoder of a DMA manager thread. It judges each decoded manager instruction against the security state of the manager. Three instruction classes are judged: starting a channel, waiting for an event, and signalling an event. The block then produces the side effects that follow from that judgement.

A manager that runs secure may do everything. It starts channels in whichever security state the instruction asks for, and it waits on or signals any event. A manager that runs non-secure may only start non-secure channels and may only touch events whose mask bit marks them non-secure. An instruction that breaks this rule does nothing else. Instead it raises a fault-status bit and one fault-type flag, and it parks the manager in a sticky faulting state. Only a kill input releases the manager from that state.

Event pulses from outside are recorded as pending bits. A wait completes at once if its event is already pending. Otherwise the manager stalls until the pulse arrives.

Top module: `dmamgr_secgate`

## Requirements
- R1: Reset (synchronous, `rst_n` low) drives every strobe and fault flag to 0 and `mgr_state_o` to READY (2'd0). It also captures `ev_mask_cfg_i` into the event security mask. Later changes of `ev_mask_cfg_i` have no effect until the next reset.
- R2: With `mgr_ns_i`=0, a GO instruction (`ins_op_i`=2'b01) always starts its channel. It gives a one-cycle `ch_start_o` one clock edge after `ins_valid_i`, with `ch_start_idx_o` equal to the channel index and `ch_ns_o` equal to the instruction's ns bit.
- R3: With `mgr_ns_i`=1, a GO instruction with ns=1 starts the channel with `ch_ns_o`=1.
- R4: With `mgr_ns_i`=1, a GO instruction with ns=0 starts nothing. It sets `fault_o` and `flt_go_err_o`, and moves the state to FAULT (2'd2).
- R5: With `mgr_ns_i`=0, a send-event instruction (2'b11) gives a one-cycle `ev_set_o` with the event index one edge later, whatever that event's mask bit is.
- R6: With `mgr_ns_i`=1, a send-event instruction sets the event when the event's mask bit is 1. When the mask bit is 0 it sets no event, sets `fault_o` and `flt_ev_err_o`, and enters FAULT.
- R7: A wait-for-event instruction (2'b10) on an event that is not pending moves the state to WAITEV (2'd1) and raises `wfe_wait_o`. When the pulse on that event is sampled, the manager returns to READY and `done_o` pulses on that same edge.
- R8: A wait on an event already pending (pulsed earlier) completes with `done_o` one edge after the instruction and clears that pending bit. A second wait on the same event therefore stalls.
- R9: With `mgr_ns_i`=1, a wait on an event whose mask bit is 0 does not stall. It sets `fault_o` and `flt_ev_err_o` and enters FAULT.
- R10: In FAULT, new instructions produce no strobe, and the fault flags stay as they are.
- R11: `kill_i` returns the manager to READY from any state, abandons a wait, and clears every fault flag on the next edge.
- R12: With `mgr_ns_i`=0, a wait on an event whose mask bit is 0 stalls and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the event mask |
| mgr_ns_i | input | 1 | Manager security: 0 secure, 1 non-secure |
| ev_mask_cfg_i | input | 32 | Event security mask loaded during reset (1 = non-secure event) |
| ins_valid_i | input | 1 | Decoded instruction present this cycle |
| ins_op_i | input | 2 | 00 none, 01 GO, 10 wait-for-event, 11 send-event |
| ins_ch_i | input | 3 | Target channel of GO |
| ins_ev_i | input | 5 | Event index of wait/send |
| ins_ns_i | input | 1 | ns bit of a GO instruction |
| ev_pulse_i | input | 32 | External event pulses, one bit per event |
| kill_i | input | 1 | Abort/clear: return to READY and clear faults |
| ch_start_o | output | 1 | Channel-start strobe |
| ch_start_idx_o | output | 3 | Channel being started |
| ch_ns_o | output | 1 | Security bit given to the started channel |
| ev_set_o | output | 1 | Raw event-status set strobe |
| ev_set_idx_o | output | 5 | Event being set |
| done_o | output | 1 | Wait-for-event completed |
| wfe_wait_o | output | 1 | Manager stalled on an event |
| fault_o | output | 1 | Manager fault status (sticky) |
| flt_go_err_o | output | 1 | Fault type: illegal GO (sticky) |
| flt_ev_err_o | output | 1 | Fault type: illegal event access (sticky) |
| mgr_state_o | output | 2 | 0 READY, 1 WAITEV, 2 FAULT |

States and transitions: READY→WAITEV (permitted wait, event not pending), READY→FAULT (illegal instruction), WAITEV→READY (event seen, or kill), FAULT→READY (kill).

## Verification
The bench builds the block with its default sizing of 8 channels and 32 events. It loads a mask in which only events 8 through 15 are non-secure. With that mask, one instance can send both secure and non-secure managers against both secure and non-secure events. The top channel index 7 and event indices on either side of the mask boundary are both reachable. Flipping the configuration input after reset shows that the mask is held from reset alone.

// File: rtl/dmamgr_secgate_pkg.sv
package dmamgr_secgate_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_GO   = 2'b01,
        OP_WFE  = 2'b10,
        OP_SEV  = 2'b11
    } mgr_op_e;

    typedef enum logic [1:0] {
        MS_READY  = 2'd0,
        MS_WAITEV = 2'd1,
        MS_FAULT  = 2'd2
    } mgr_state_e;
endpackage

// File: rtl/secgate_rules.sv
module secgate_rules
    import dmamgr_secgate_pkg::*;
(
    input  logic    mgr_ns,
    input  mgr_op_e op,
    input  logic    ins_ns,
    input  logic    ev_nonsec,
    output logic    allow,
    output logic    go_err,
    output logic    ev_err
);
    always_comb begin
        go_err = 1'b0;
        ev_err = 1'b0;
        if (mgr_ns) begin
            unique case (op)
                OP_GO:          go_err = !ins_ns;
                OP_WFE, OP_SEV: ev_err = !ev_nonsec;
                default:        ;
            endcase
        end
        allow = !(go_err || ev_err);
    end
endmodule

// File: rtl/secgate_evmask.sv
module secgate_evmask #(
    parameter int NUM_EV = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] cfg,
    output logic [NUM_EV-1:0] mask
);
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= cfg;
    end
endmodule

// File: rtl/secgate_evpend.sv
module secgate_evpend #(
    parameter int NUM_EV = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] pulse,
    input  logic [NUM_EV-1:0] clr,
    output logic [NUM_EV-1:0] pend
);
    for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) pend[i] <= 1'b0;
            else        pend[i] <= (pend[i] | pulse[i]) & ~clr[i];
        end
    end
endmodule

// File: rtl/dmamgr_secgate.sv
module dmamgr_secgate
    import dmamgr_secgate_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int NUM_EV = 32,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int EV_W  = $clog2(NUM_EV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgr_ns_i,
    input  logic [NUM_EV-1:0] ev_mask_cfg_i,
    input  logic              ins_valid_i,
    input  logic [1:0]        ins_op_i,
    input  logic [CH_W-1:0]   ins_ch_i,
    input  logic [EV_W-1:0]   ins_ev_i,
    input  logic              ins_ns_i,
    input  logic [NUM_EV-1:0] ev_pulse_i,
    input  logic              kill_i,
    output logic              ch_start_o,
    output logic [CH_W-1:0]   ch_start_idx_o,
    output logic              ch_ns_o,
    output logic              ev_set_o,
    output logic [EV_W-1:0]   ev_set_idx_o,
    output logic              done_o,
    output logic              wfe_wait_o,
    output logic              fault_o,
    output logic              flt_go_err_o,
    output logic              flt_ev_err_o,
    output logic [1:0]        mgr_state_o
);
    mgr_state_e        st_q, st_d;
    mgr_op_e           op;
    logic [EV_W-1:0]   wev_q, wev_d;
    logic [NUM_EV-1:0] mask_q, pend_q, clr_vec;
    logic              allow, go_err, ev_err;
    logic              hit_new, hit_wait;
    logic              start_d, set_d, done_d, goerr_set, everr_set;

    assign op = mgr_op_e'(ins_op_i);

    secgate_evmask #(.NUM_EV(NUM_EV)) u_mask (
        .clk(clk), .rst_n(rst_n), .cfg(ev_mask_cfg_i), .mask(mask_q)
    );

    secgate_evpend #(.NUM_EV(NUM_EV)) u_pend (
        .clk(clk), .rst_n(rst_n), .pulse(ev_pulse_i), .clr(clr_vec), .pend(pend_q)
    );

    secgate_rules u_rules (
        .mgr_ns(mgr_ns_i), .op(op), .ins_ns(ins_ns_i), .ev_nonsec(mask_q[ins_ev_i]),
        .allow(allow), .go_err(go_err), .ev_err(ev_err)
    );

    assign hit_new  = pend_q[ins_ev_i] | ev_pulse_i[ins_ev_i];
    assign hit_wait = pend_q[wev_q]    | ev_pulse_i[wev_q];

    // next state and next strobes
    always_comb begin
        st_d      = st_q;
        wev_d     = wev_q;
        start_d   = 1'b0;
        set_d     = 1'b0;
        done_d    = 1'b0;
        goerr_set = 1'b0;
        everr_set = 1'b0;
        clr_vec   = '0;
        unique case (st_q)
            MS_READY: begin
                if (!kill_i && ins_valid_i && op != OP_NONE) begin
                    if (!allow) begin
                        st_d      = MS_FAULT;
                        goerr_set = go_err;
                        everr_set = ev_err;
                    end else begin
                        unique case (op)
                            OP_GO:  start_d = 1'b1;
                            OP_SEV: set_d   = 1'b1;
                            OP_WFE: begin
                                if (hit_new) begin
                                    done_d            = 1'b1;
                                    clr_vec[ins_ev_i] = 1'b1;
                                end else begin
                                    st_d  = MS_WAITEV;
                                    wev_d = ins_ev_i;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end
            MS_WAITEV: begin
                if (kill_i) begin
                    st_d = MS_READY;
                end else if (hit_wait) begin
                    done_d         = 1'b1;
                    clr_vec[wev_q] = 1'b1;
                    st_d           = MS_READY;
                end
            end
            MS_FAULT: begin
                if (kill_i) st_d = MS_READY;
            end
            default: st_d = MS_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= MS_READY;
            wev_q <= '0;
        end else begin
            st_q  <= st_d;
            wev_q <= wev_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_start_o     <= 1'b0;
            ch_start_idx_o <= '0;
            ch_ns_o        <= 1'b0;
            ev_set_o       <= 1'b0;
            ev_set_idx_o   <= '0;
            done_o         <= 1'b0;
            fault_o        <= 1'b0;
            flt_go_err_o   <= 1'b0;
            flt_ev_err_o   <= 1'b0;
        end else begin
            ch_start_o     <= start_d;
            ch_start_idx_o <= ins_ch_i;
            ch_ns_o        <= ins_ns_i;
            ev_set_o       <= set_d;
            ev_set_idx_o   <= ins_ev_i;
            done_o         <= done_d;
            if (kill_i) begin
                fault_o      <= 1'b0;
                flt_go_err_o <= 1'b0;
                flt_ev_err_o <= 1'b0;
            end else begin
                fault_o      <= fault_o | goerr_set | everr_set;
                flt_go_err_o <= flt_go_err_o | goerr_set;
                flt_ev_err_o <= flt_ev_err_o | everr_set;
            end
        end
    end

    assign wfe_wait_o  = (st_q == MS_WAITEV);
    assign mgr_state_o = st_q;
endmodule

// File: rtl/dmamgr_secgate_chk.sv
module dmamgr_secgate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mgr_ns_i,
    input logic       ins_valid_i,
    input logic [1:0] ins_op_i,
    input logic       ins_ns_i,
    input logic       kill_i,
    input logic       ch_start_o,
    input logic       ch_ns_o,
    input logic       ev_set_o,
    input logic       done_o,
    input logic       fault_o,
    input logic       flt_go_err_o,
    input logic       flt_ev_err_o,
    input logic [1:0] mgr_state_o
);
    // R3
    nsmgr_nsch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_start_o && $past(mgr_ns_i)) |-> ch_ns_o);

    // R4
    goerr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_go_err_o) |-> $past(mgr_ns_i && ins_valid_i && ins_op_i == 2'b01 && !ins_ns_i));

    // R10
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgr_state_o == 2'd2 && !kill_i) |=> (mgr_state_o == 2'd2 && fault_o));

    // R11
    kill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> (!fault_o && !flt_go_err_o && !flt_ev_err_o && mgr_state_o == 2'd0));

    // R7
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> mgr_state_o == 2'd0);

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_start_o, ev_set_o, done_o}));
endmodule

bind dmamgr_secgate dmamgr_secgate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mgr_ns_i(mgr_ns_i), .ins_valid_i(ins_valid_i),
    .ins_op_i(ins_op_i), .ins_ns_i(ins_ns_i), .kill_i(kill_i),
    .ch_start_o(ch_start_o), .ch_ns_o(ch_ns_o), .ev_set_o(ev_set_o), .done_o(done_o),
    .fault_o(fault_o), .flt_go_err_o(flt_go_err_o), .flt_ev_err_o(flt_ev_err_o),
    .mgr_state_o(mgr_state_o)
);

// File: tb/dmamgr_secgate_bench.sv
`timescale 1ns/1ps
module dmamgr_secgate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgr_ns_i = 1'b0;
    logic [31:0] ev_mask_cfg_i = 32'h0000_FF00;
    logic        ins_valid_i = 1'b0;
    logic [1:0]  ins_op_i = 2'b00;
    logic [2:0]  ins_ch_i = '0;
    logic [4:0]  ins_ev_i = '0;
    logic        ins_ns_i = 1'b0;
    logic [31:0] ev_pulse_i = '0;
    logic        kill_i = 1'b0;
    logic        ch_start_o, ch_ns_o, ev_set_o, done_o, wfe_wait_o;
    logic        fault_o, flt_go_err_o, flt_ev_err_o;
    logic [2:0]  ch_start_idx_o;
    logic [4:0]  ev_set_idx_o;
    logic [1:0]  mgr_state_o;

    dmamgr_secgate u_dmamgr_secgate (.*);

    always #2.5 clk = ~clk;

    typedef struct {int kind; int idx; int ns; string req;} exp_t;
    exp_t  sbq[$];
    int    n_run = 0, n_fail = 0;
    string cur_req = "R1";
    bit    finished = 0;

    task automatic check(input int act, input int exp, input string req, input string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_item(input int kind, input int idx, input int ns, input string req);
        exp_t e;
        e.kind = kind; e.idx = idx; e.ns = ns; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic issue(input logic [1:0] op, input int ch, input int ev, input logic ns);
        @(negedge clk);
        ins_valid_i = 1'b1; ins_op_i = op; ins_ch_i = 3'(ch); ins_ev_i = 5'(ev); ins_ns_i = ns;
        @(negedge clk);
        ins_valid_i = 1'b0; ins_op_i = 2'b00;
    endtask

    task automatic pulse(input int ev);
        @(negedge clk);
        ev_pulse_i = 32'd1 << ev;
        @(negedge clk);
        ev_pulse_i = '0;
    endtask

    task automatic kill();
        @(negedge clk);
        kill_i = 1'b1;
        @(negedge clk);
        kill_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: kind 1 start, 2 event set, 3 done
    always @(negedge clk) begin
        if (rst_n && !finished && (ch_start_o || ev_set_o || done_o)) begin
            int k, ix, ns;
            k  = ch_start_o ? 1 : (ev_set_o ? 2 : 3);
            ix = ch_start_o ? int'(ch_start_idx_o) : (ev_set_o ? int'(ev_set_idx_o) : 0);
            ns = ch_start_o ? int'(ch_ns_o) : 0;
            if (sbq.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL %s unexpected strobe: actual kind %0d idx %0d expected none", cur_req, k, ix);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(k,  e.kind, e.req, "strobe kind");
                check(ix, e.idx,  e.req, "index");
                check(ns, e.ns,   e.req, "channel ns");
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        // R1 reset state
        check(int'(ch_start_o | ev_set_o | done_o), 0, "R1", "strobes in reset");
        check(int'(mgr_state_o), 0, "R1", "state in reset");
        rst_n = 1'b1;
        ev_mask_cfg_i = 32'h0;   // R1: must not alter the captured mask
        idle(2);
        check(int'(fault_o | flt_go_err_o | flt_ev_err_o), 0, "R1", "fault flags after reset");

        // secure manager
        cur_req = "R2";
        expect_item(1, 3, 0, "R2"); issue(2'b01, 3, 0, 1'b0);
        expect_item(1, 7, 1, "R2"); issue(2'b01, 7, 0, 1'b1);
        cur_req = "R5";
        expect_item(2, 2, 0, "R5"); issue(2'b11, 0, 2, 1'b0);
        cur_req = "R12";
        issue(2'b10, 0, 4, 1'b0);
        idle(1);
        check(int'(wfe_wait_o), 1, "R12", "secure wait on secure event stalls");
        check(int'(mgr_state_o), 1, "R7", "state WAITEV");
        expect_item(3, 0, 0, "R7"); pulse(4);
        check(int'(mgr_state_o), 0, "R7", "state READY after event");

        // R8 pending event
        cur_req = "R8";
        pulse(9); idle(1);
        expect_item(3, 0, 0, "R8"); issue(2'b10, 0, 9, 1'b0);
        check(int'(wfe_wait_o), 0, "R8", "pending wait does not stall");
        issue(2'b10, 0, 9, 1'b0);
        idle(1);
        check(int'(wfe_wait_o), 1, "R8", "pending bit consumed, second wait stalls");
        cur_req = "R11";
        kill(); idle(1);
        check(int'(mgr_state_o), 0, "R11", "kill abandons wait");

        // non-secure manager
        mgr_ns_i = 1'b1;
        cur_req = "R3";
        expect_item(1, 5, 1, "R3"); issue(2'b01, 5, 0, 1'b1);
        cur_req = "R6";
        expect_item(2, 8, 0, "R6"); issue(2'b11, 0, 8, 1'b0);
        cur_req = "R7";
        issue(2'b10, 0, 10, 1'b0);
        idle(1);
        check(int'(wfe_wait_o), 1, "R7", "non-secure wait on non-secure event stalls");
        expect_item(3, 0, 0, "R7"); pulse(10);

        cur_req = "R4";
        issue(2'b01, 2, 0, 1'b0);
        check(int'(fault_o), 1, "R4", "fault status");
        check(int'(flt_go_err_o), 1, "R4", "go error flag");
        check(int'(mgr_state_o), 2, "R4", "state FAULT");
        cur_req = "R10";
        issue(2'b11, 0, 12, 1'b0);
        idle(2);
        check(int'(flt_ev_err_o), 0, "R10", "ignored instruction leaves event flag");
        check(int'(flt_go_err_o), 1, "R10", "go flag sticky");
        cur_req = "R11";
        kill(); idle(1);
        check(int'(fault_o | flt_go_err_o), 0, "R11", "kill clears faults");

        cur_req = "R6";
        issue(2'b11, 0, 3, 1'b0);
        check(int'(flt_ev_err_o), 1, "R6", "secure event send faults");
        check(int'(mgr_state_o), 2, "R6", "state FAULT");
        kill();
        cur_req = "R9";
        issue(2'b10, 0, 3, 1'b0);
        check(int'(wfe_wait_o), 0, "R9", "illegal wait does not stall");
        check(int'(flt_ev_err_o & fault_o), 1, "R9", "event fault flags");
        kill(); idle(3);

        check(sbq.size(), 0, "R2", "all expected strobes seen");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule